// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Acknowledge Sequencer

This block joins two eight-line interrupt slices, a primary and a secondary, into one sixteen-input interrupt controller. Each slice latches requests as either edges or levels, honours a per-line mask, and tracks which lines are in service, with a lower line index always taking precedence. Whenever the secondary slice has a request ready to deliver, the block forwards it into the primary slice's cascade line (line 2) as an edge. The primary slice's decision drives a single interrupt output toward the processor.

When the processor asks for an acknowledge, the block picks the primary winner and marks it in service. If that winner is the cascade line, it does the same on the secondary slice. It then returns an 8-bit vector built from a 5-bit programmed base and the 3-bit line number. If a slice has nothing to offer at that moment, the vector carries line 7 to mark a spurious interrupt. A poll read gives the same arbitration without a vector cycle. It returns a status byte and retires the winning line at once. A non-specific end-of-service command frees the highest-precedence in-service line of either slice.

Top module: `cascade_irq_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cpu_int`, `ack_valid` and `poll_valid` are 0. Reset clears all request and in-service state and returns every line to edge mode.
- R2: Inputs 0-7 belong to the primary slice and 8-15 to the secondary, with the line number taken from bits [2:0]. Within a slice the lower number wins. A line whose `irq_mask` bit is 1 is not considered, but its latched edge survives until it is unmasked.
- R3: In edge mode a rising input latches a request, and an acknowledge clears it. An input that is held high raises no further request.
- R4: A ready request in the secondary slice sets the primary cascade line (2), and `cpu_int` follows. Input `irq_in[2]` has no effect.
- R5: One cycle after `ack_req`, `ack_valid` is high for exactly one cycle. For a primary winner other than line 2, `ack_vector` = {`master_base`, line}, and the line enters service.
- R6: If the primary winner is line 2, the secondary winner enters service and `ack_vector` = {`slave_base`, line}.
- R7: If the primary winner is line 2 and the secondary slice has no candidate, `ack_vector` = {`slave_base`, 3'd7}.
- R8: If the primary slice has no winner, `ack_vector` = {`master_base`, 3'd7} and no state changes.
- R9: One cycle after `poll_req`, `poll_valid` pulses. `poll_data` is 0x80 OR the winning line of the selected slice (`poll_slave`=1 selects the secondary), or 0x00 if there is none. The winner's request and in-service bits are cleared. A secondary poll also clears primary line 2.
- R10: A trigger write stores `trig_data` AND 0xF8 on the primary and AND 0xDE on the secondary, where a bit value of 1 means level mode. Primary lines 0-2 and secondary lines 8 and 13 therefore stay edge. A level-mode request follows its input and survives an acknowledge.
- R11: A line in service blocks requests of equal or lower precedence in its slice. `eoi_req` clears the highest-precedence in-service bit of the slice picked by `eoi_slave`.
- R12: `cpu_int` sampled together with `ack_valid` or `poll_valid` already reflects the state after that acknowledge or poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Interrupt request inputs |
| irq_mask | input | 16 | Per-line mask, 1 = masked |
| master_base | input | 5 | Vector base of the primary slice |
| slave_base | input | 5 | Vector base of the secondary slice |
| trig_wr | input | 1 | Trigger-mode write strobe |
| trig_slave | input | 1 | Trigger write target, 1 = secondary |
| trig_data | input | 8 | Trigger-mode bits, 1 = level |
| cpu_int | output | 1 | Interrupt request to the processor |
| ack_req | input | 1 | Acknowledge request |
| ack_valid | output | 1 | Acknowledge response strobe |
| ack_vector | output | 8 | Interrupt vector |
| poll_req | input | 1 | Poll read request |
| poll_slave | input | 1 | Poll target, 1 = secondary |
| poll_valid | output | 1 | Poll response strobe |
| poll_data | output | 8 | Poll status byte |
| eoi_req | input | 1 | Non-specific end-of-service command |
| eoi_slave | input | 1 | End-of-service target, 1 = secondary |

## Verification
The assertions watch the handshakes on every cycle. Each response must follow its own request, and an acknowledge issued while `cpu_int` is low must return the primary spurious vector. Every vector must carry one of the two bases, and every poll byte must have the legal shape. Other behaviour depends on sequences of stimulus, and only the bench scenarios can show it. That covers the cascade forwarding, secondary winner selection, the spurious secondary case, in-service blocking and its release, and the difference between edge and level lines under the trigger write masks.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int LINES         = 8;
    localparam int IDXW          = $clog2(LINES);
    localparam int VECW          = 8;
    localparam int BASEW         = VECW - IDXW;
    localparam int NUM_IN        = 2 * LINES;
    localparam int CASCADE_LINE  = 2;
    localparam int SPURIOUS_LINE = LINES - 1;
    localparam logic [LINES-1:0] PRI_TRIG_WMASK = 8'hF8;
    localparam logic [LINES-1:0] SEC_TRIG_WMASK = 8'hDE;

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } pick_t;

    typedef enum logic [1:0] {OP_NONE, OP_ACK, OP_POLL, OP_EOI} op_e;

    // lowest set index wins
    function automatic pick_t pick_lowest(input logic [LINES-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDXW'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/irq_slice.sv
module irq_slice
    import cas_pkg::*;
#(
    parameter logic [LINES-1:0] TRIG_WMASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] line_mask,
    input  logic [LINES-1:0] ext_set,
    input  logic [LINES-1:0] take_mask,
    input  logic [LINES-1:0] drop_mask,
    input  logic             eoi,
    input  logic             trig_wr,
    input  logic [LINES-1:0] trig_data,
    output pick_t            want
);
    logic [LINES-1:0] req_q, svc_q, prev_q, trig_q;
    logic [LINES-1:0] req_d, svc_d;
    pick_t            top, cur;

    always_comb begin
        top       = pick_lowest(req_q & ~line_mask);
        cur       = pick_lowest(svc_q);
        want.idx  = top.idx;
        want.hit  = top.hit && (!cur.hit || (top.idx < cur.idx));
    end

    always_comb begin
        req_d = req_q;
        for (int i = 0; i < LINES; i++) begin
            if (trig_q[i])
                req_d[i] = line_in[i];
            else if (line_in[i] && !prev_q[i])
                req_d[i] = 1'b1;
        end
        req_d = req_d | ext_set;
        req_d = req_d & ~(take_mask & ~trig_q);
        req_d = req_d & ~drop_mask;

        svc_d = (svc_q | take_mask) & ~drop_mask;
        if (eoi && cur.hit)
            svc_d[cur.idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            svc_q  <= '0;
            prev_q <= '0;
            trig_q <= '0;
        end else begin
            req_q  <= req_d;
            svc_q  <= svc_d;
            prev_q <= line_in;
            if (trig_wr)
                trig_q <= trig_data & TRIG_WMASK;
        end
    end
endmodule

// File: rtl/cascade_irq_sequencer.sv
module cascade_irq_sequencer
    import cas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [NUM_IN-1:0] irq_mask,
    input  logic [BASEW-1:0]  master_base,
    input  logic [BASEW-1:0]  slave_base,
    input  logic              trig_wr,
    input  logic              trig_slave,
    input  logic [LINES-1:0]  trig_data,
    output logic              cpu_int,
    input  logic              ack_req,
    output logic              ack_valid,
    output logic [VECW-1:0]   ack_vector,
    input  logic              poll_req,
    input  logic              poll_slave,
    output logic              poll_valid,
    output logic [VECW-1:0]   poll_data,
    input  logic              eoi_req,
    input  logic              eoi_slave
);
    localparam logic [LINES-1:0] CAS_BIT = LINES'(1) << CASCADE_LINE;
    localparam logic [IDXW-1:0]  SPUR    = IDXW'(SPURIOUS_LINE);

    pick_t            m_want, s_want, sel;
    op_e              op;
    logic [LINES-1:0] m_take, s_take, m_drop, s_drop, m_ext;
    logic             m_eoi, s_eoi;
    logic [VECW-1:0]  vec_d, poll_d;

    assign m_ext = s_want.hit ? CAS_BIT : '0;

    irq_slice #(.TRIG_WMASK(PRI_TRIG_WMASK)) u_pri (
        .clk       (clk),
        .rst       (rst),
        .line_in   (irq_in[LINES-1:0] & ~CAS_BIT),
        .line_mask (irq_mask[LINES-1:0]),
        .ext_set   (m_ext),
        .take_mask (m_take),
        .drop_mask (m_drop),
        .eoi       (m_eoi),
        .trig_wr   (trig_wr && !trig_slave),
        .trig_data (trig_data),
        .want      (m_want)
    );

    irq_slice #(.TRIG_WMASK(SEC_TRIG_WMASK)) u_sec (
        .clk       (clk),
        .rst       (rst),
        .line_in   (irq_in[NUM_IN-1:LINES]),
        .line_mask (irq_mask[NUM_IN-1:LINES]),
        .ext_set   ('0),
        .take_mask (s_take),
        .drop_mask (s_drop),
        .eoi       (s_eoi),
        .trig_wr   (trig_wr && trig_slave),
        .trig_data (trig_data),
        .want      (s_want)
    );

    always_comb begin
        if (ack_req)       op = OP_ACK;
        else if (poll_req) op = OP_POLL;
        else if (eoi_req)  op = OP_EOI;
        else               op = OP_NONE;
    end

    always_comb begin
        m_take = '0;
        s_take = '0;
        m_drop = '0;
        s_drop = '0;
        m_eoi  = 1'b0;
        s_eoi  = 1'b0;
        vec_d  = {master_base, SPUR};
        poll_d = '0;
        sel    = poll_slave ? s_want : m_want;
        case (op)
            OP_ACK: begin
                if (m_want.hit) begin
                    m_take = LINES'(1) << m_want.idx;
                    if (m_want.idx == IDXW'(CASCADE_LINE)) begin
                        if (s_want.hit) begin
                            s_take = LINES'(1) << s_want.idx;
                            vec_d  = {slave_base, s_want.idx};
                        end else begin
                            vec_d  = {slave_base, SPUR};
                        end
                    end else begin
                        vec_d = {master_base, m_want.idx};
                    end
                end
            end
            OP_POLL: begin
                if (sel.hit) begin
                    poll_d = {1'b1, {(VECW-1-IDXW){1'b0}}, sel.idx};
                    if (poll_slave) begin
                        s_drop = LINES'(1) << sel.idx;
                        m_drop = CAS_BIT;
                    end else begin
                        m_drop = LINES'(1) << sel.idx;
                    end
                end
            end
            OP_EOI: begin
                m_eoi = !eoi_slave;
                s_eoi = eoi_slave;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
            poll_valid <= 1'b0;
            poll_data  <= '0;
        end else begin
            ack_valid  <= (op == OP_ACK);
            poll_valid <= (op == OP_POLL);
            if (op == OP_ACK)  ack_vector <= vec_d;
            if (op == OP_POLL) poll_data  <= poll_d;
        end
    end

    assign cpu_int = m_want.hit;
endmodule

// File: rtl/cas_chk.sv
module cas_chk
    import cas_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cpu_int,
    input logic             ack_req,
    input logic             ack_valid,
    input logic [VECW-1:0]  ack_vector,
    input logic             poll_req,
    input logic             poll_valid,
    input logic [VECW-1:0]  poll_data,
    input logic [BASEW-1:0] master_base,
    input logic [BASEW-1:0] slave_base
);
    // R5: a response strobe only follows a request
    p_ack_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(ack_req));

    // R9: poll response follows a poll that no acknowledge pre-empted
    p_poll_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
        poll_valid |-> ($past(poll_req) && !$past(ack_req)));

    // R9: status byte shape
    p_poll_format_r9: assert property (@(posedge clk) disable iff (rst)
        poll_valid |-> ((poll_data[VECW-2:IDXW] == '0) &&
                        (poll_data[VECW-1] || (poll_data[IDXW-1:0] == '0))));

    // R6: every vector is built on one of the two bases
    p_ack_base_r6: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> ((ack_vector[VECW-1:IDXW] == $past(master_base)) ||
                       (ack_vector[VECW-1:IDXW] == $past(slave_base))));

    // R8: acknowledge with no primary winner gives the spurious vector
    p_master_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !cpu_int) |=>
            (ack_valid && (ack_vector == {$past(master_base), IDXW'(SPURIOUS_LINE)})));
endmodule

bind cascade_irq_sequencer cas_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_int     (cpu_int),
    .ack_req     (ack_req),
    .ack_valid   (ack_valid),
    .ack_vector  (ack_vector),
    .poll_req    (poll_req),
    .poll_valid  (poll_valid),
    .poll_data   (poll_data),
    .master_base (master_base),
    .slave_base  (slave_base)
);

// File: tb/cascade_irq_sequencer_tb.sv
`timescale 1ns/1ps
module cascade_irq_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] irq_in = '0, irq_mask = '0;
    logic [4:0]  master_base = 5'h08, slave_base = 5'h0E;
    logic        trig_wr = 0, trig_slave = 0;
    logic [7:0]  trig_data = '0;
    logic        cpu_int, ack_req = 0, ack_valid, poll_req = 0, poll_slave = 0, poll_valid;
    logic [7:0]  ack_vector, poll_data;
    logic        eoi_req = 0, eoi_slave = 0;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    cascade_irq_sequencer u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_mask(irq_mask),
        .master_base(master_base), .slave_base(slave_base),
        .trig_wr(trig_wr), .trig_slave(trig_slave), .trig_data(trig_data),
        .cpu_int(cpu_int), .ack_req(ack_req), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .poll_req(poll_req), .poll_slave(poll_slave),
        .poll_valid(poll_valid), .poll_data(poll_data),
        .eoi_req(eoi_req), .eoi_slave(eoi_slave)
    );

    typedef struct packed {
        logic [3:0] line;
        logic       exp_int;
        logic [7:0] exp_vec;
    } row_t;

    localparam row_t ROWS [7] = '{
        '{4'd0,  1'b1, 8'h40},
        '{4'd5,  1'b1, 8'h45},
        '{4'd7,  1'b1, 8'h47},
        '{4'd2,  1'b0, 8'h00},
        '{4'd8,  1'b1, 8'h70},
        '{4'd11, 1'b1, 8'h73},
        '{4'd15, 1'b1, 8'h77}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack(output logic [7:0] v);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk("R5 ack_valid", {7'b0, ack_valid}, 8'h01);
        v = ack_vector;
    endtask

    task automatic do_poll(input logic sec, output logic [7:0] d);
        poll_req = 1'b1;
        poll_slave = sec;
        @(negedge clk);
        poll_req = 1'b0;
        chk("R9 poll_valid", {7'b0, poll_valid}, 8'h01);
        d = poll_data;
    endtask

    task automatic do_eoi(input logic sec);
        eoi_req = 1'b1;
        eoi_slave = sec;
        @(negedge clk);
        eoi_req = 1'b0;
    endtask

    task automatic trig_write(input logic sec, input logic [7:0] d);
        trig_wr = 1'b1;
        trig_slave = sec;
        trig_data = d;
        @(negedge clk);
        trig_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1;
        tick(3);
        chk("R1 cpu_int in reset", {7'b0, cpu_int}, 8'h00);
        chk("R1 ack_valid in reset", {7'b0, ack_valid}, 8'h00);
        chk("R1 poll_valid in reset", {7'b0, poll_valid}, 8'h00);
        rst = 1'b0;
        tick(1);
        chk("R1 cpu_int after reset", {7'b0, cpu_int}, 8'h00);

        // table walk: single line raised, acknowledged, retired
        for (int k = 0; k < 7; k++) begin
            irq_in[ROWS[k].line] = 1'b1;
            tick(3);
            chk(ROWS[k].line == 4'd2 ? "R4 line 2 input ignored" : "R4 cpu_int raised",
                {7'b0, cpu_int}, {7'b0, ROWS[k].exp_int});
            if (ROWS[k].exp_int) begin
                do_ack(v);
                chk(ROWS[k].line >= 4'd8 ? "R6 cascaded vector" : "R5 primary vector",
                    v, ROWS[k].exp_vec);
                chk("R12 cpu_int after ack", {7'b0, cpu_int}, 8'h00);
                tick(1);
                chk("R5 ack_valid single pulse", {7'b0, ack_valid}, 8'h00);
                irq_in[ROWS[k].line] = 1'b0;
                if (ROWS[k].line >= 4'd8) do_eoi(1'b1);
                do_eoi(1'b0);
            end
            irq_in[ROWS[k].line] = 1'b0;
            tick(3);
            chk("R3 no request after retire", {7'b0, cpu_int}, 8'h00);
        end

        // R8: acknowledge with nothing pending
        do_ack(v);
        chk("R8 primary spurious vector", v, 8'h47);
        chk("R8 no state change", {7'b0, cpu_int}, 8'h00);

        // R2: mask holds a latched edge back
        irq_mask[4] = 1'b1;
        irq_in[4] = 1'b1;
        tick(3);
        chk("R2 masked line silent", {7'b0, cpu_int}, 8'h00);
        irq_mask[4] = 1'b0;
        tick(1);
        chk("R2 unmasked edge kept", {7'b0, cpu_int}, 8'h01);
        do_ack(v);
        chk("R2 vector of line 4", v, 8'h44);
        irq_in[4] = 1'b0;
        do_eoi(1'b0);

        // R10/R11/R3: primary trigger mask, blocking by in-service
        trig_write(1'b0, 8'hFF);
        irq_in[1] = 1'b1;
        irq_in[3] = 1'b1;
        tick(3);
        do_ack(v);
        chk("R2 lower line wins", v, 8'h41);
        chk("R11 in-service blocks line 3", {7'b0, cpu_int}, 8'h00);
        do_eoi(1'b0);
        chk("R11 end-of-service releases", {7'b0, cpu_int}, 8'h01);
        do_ack(v);
        chk("R10 line 3 vector", v, 8'h43);
        do_eoi(1'b0);
        tick(3);
        chk("R10 level request survives ack", {7'b0, cpu_int}, 8'h01);
        do_ack(v);
        chk("R10 level line again", v, 8'h43);
        irq_in[3] = 1'b0;
        do_eoi(1'b0);
        tick(3);
        chk("R3 held edge line 1 no re-request", {7'b0, cpu_int}, 8'h00);
        irq_in[1] = 1'b0;
        trig_write(1'b0, 8'h00);

        // R10: secondary trigger mask
        trig_write(1'b1, 8'hFF);
        irq_in[8] = 1'b1;
        tick(3);
        do_ack(v);
        chk("R6 line 8 vector", v, 8'h70);
        do_eoi(1'b1);
        do_eoi(1'b0);
        tick(3);
        chk("R10 line 8 forced edge", {7'b0, cpu_int}, 8'h00);
        irq_in[9] = 1'b1;
        tick(3);
        do_ack(v);
        chk("R6 line 9 vector", v, 8'h71);
        do_eoi(1'b1);
        do_eoi(1'b0);
        tick(3);
        chk("R10 line 9 level kept", {7'b0, cpu_int}, 8'h01);
        irq_in[9] = 1'b0;
        irq_in[8] = 1'b0;
        tick(3);
        do_poll(1'b0, v);
        chk("R9 poll primary cascade line", v, 8'h82);
        chk("R12 cpu_int after poll", {7'b0, cpu_int}, 8'h00);
        trig_write(1'b1, 8'h00);
        tick(2);

        // R7: cascade latched but secondary candidate masked away
        irq_in[9] = 1'b1;
        tick(3);
        irq_mask[9] = 1'b1;
        tick(1);
        chk("R4 cascade still latched", {7'b0, cpu_int}, 8'h01);
        do_ack(v);
        chk("R7 secondary spurious vector", v, 8'h77);
        irq_in[9] = 1'b0;
        do_eoi(1'b0);
        irq_mask[9] = 1'b0;
        tick(3);
        chk("R4 unmasked secondary forwarded", {7'b0, cpu_int}, 8'h01);
        do_poll(1'b1, v);
        chk("R9 poll secondary", v, 8'h81);
        chk("R9 secondary poll clears line 2", {7'b0, cpu_int}, 8'h00);
        do_poll(1'b0, v);
        chk("R9 poll empty", v, 8'h00);

        // R9: primary poll
        irq_in[6] = 1'b1;
        tick(3);
        do_poll(1'b0, v);
        chk("R9 poll line 6", v, 8'h86);
        chk("R9 poll retires line", {7'b0, cpu_int}, 8'h00);
        irq_in[6] = 1'b0;
        tick(2);

        done = 1;
        finish_run();
    end
endmodule